// File: doc/BRIEF.md
# Interpolating Degree Clock Generator

This block sits behind a toothed-wheel sensor and fills the gap between two teeth with evenly spaced "degree" ticks, each of which can advance an external angle counter by one. It timestamps every qualifying sensor edge against a free-running 16-bit timebase. It schedules a compare one interval after the last reference point. Each time the compare fires, the next one is scheduled a further interval later.

On every tooth after the first, the block rebuilds the tooth period. The period is the number of ticks already issued times the interval, plus the time left over since the last tick. From that period it derives the next interval as period times an 8-bit ratio divided by 1024. Ticks feed the angle counter only while the degree count is below a host modulus. A stall interrupt is raised once the count reaches a stall threshold. Tooth numbering and synchronization belong to a companion block, which receives a one-cycle strobe on each tooth after the first.

Top module: `deg_clk_interp`

## Requirements
- R1: On `init`, the interval takes `interval_seed`, except that a seed of zero or with bit 15 set (negative as a signed value) becomes 0x8000. The degree count clears, the first-tooth state clears and the pending compare is disarmed. `init` takes priority over sensor edges and compares in the same cycle.
- R2: The first qualifying edge after `init` arms a compare at capture time plus interval. It raises no `edge_seen` and does not change `period`.
- R3: A compare fires in the cycle where `timebase` equals the scheduled value, using modular 16-bit arithmetic. The compare time becomes the reference, the next compare is set one interval later, and `degree_count` increments, saturating at its maximum. Results appear on the outputs one clock after the cycle that sampled the event.
- R4: On a compare whose incremented degree count is below `modulus`, `angle_inc` pulses for one cycle.
- R5: On a compare whose incremented degree count is at or above `modulus`, `stall_irq` pulses if the count is also at or above `stall_count`; otherwise neither pulse is produced. `angle_inc` and `stall_irq` are never high together.
- R6: On each later qualifying edge, `period` becomes degree_count × interval + (capture − reference) mod 2^16, truncated to 24 bits. All 24 bits are written in the same cycle.
- R7: In that same update, the interval becomes floor(floor(period/4) × ratio / 256).
- R8: If period/4 exceeds 0xFFFF, 0xFFFF is used in its place before the ratio multiply.
- R9: On each later qualifying edge, `degree_count` returns to 0, the capture becomes the reference, the next compare is set at capture plus the new interval, and `edge_seen` pulses for one cycle.
- R10: With `edge_rising` = 1 only 0→1 transitions of `sensor_pin` are qualifying edges; with 0 only 1→0 transitions are. Transitions of the other direction have no effect.
- R11: When a qualifying edge and a compare fall in the same cycle, the edge is handled and the compare is dropped.
- R12: After reset, the interval is 0x8000, `period` and `degree_count` are 0, all pulses are low and no compare is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init | input | 1 | One-cycle initialization request |
| interval_seed | input | 16 | Interval loaded on init (subject to R1 rule) |
| sensor_pin | input | 1 | Toothed-wheel sensor level |
| edge_rising | input | 1 | 1 = rising edges qualify, 0 = falling edges qualify |
| timebase | input | 16 | Free-running timebase count |
| modulus | input | 8 | Ticks per tooth that advance the angle counter |
| stall_count | input | 8 | Degree count at which the stall interrupt starts |
| ratio | input | 8 | Interval scale: interval = period × ratio / 1024 |
| period | output | 24 | Last measured tooth period |
| interval | output | 16 | Current tick spacing |
| degree_count | output | 8 | Ticks issued since the last tooth |
| angle_inc | output | 1 | One-cycle angle-counter increment |
| stall_irq | output | 1 | One-cycle stall interrupt |
| edge_seen | output | 1 | One-cycle strobe on each qualifying edge after the first |

## Verification
The tick scheduler is driven with tooth spacings that are steady, then shorter, then longer than the previous one. Steady spacing confirms the interval converges from the ratio. A shorter tooth shows the leftover term of the period and the reset of the degree count. A longer tooth carries the count past the modulus and the stall threshold, which separates angle pulses from silent ticks and stall interrupts. The timebase is also stepped in large strides, so that many ticks of a 0x8000 interval push the period past 2^18 and exercise the saturation. One tooth is placed exactly on a scheduled compare to show that edge priority removes that tick. Runs in falling-edge mode interleave rising transitions that must leave no trace.

// File: rtl/deg_clk_interp.sv
module deg_clk_interp #(
  parameter int TB_W  = 16,
  parameter int DEG_W = 8,
  parameter int RAT_W = 8,
  localparam int PER_W = DEG_W + TB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic [TB_W-1:0]  interval_seed,
  input  logic             sensor_pin,
  input  logic             edge_rising,
  input  logic [TB_W-1:0]  timebase,
  input  logic [DEG_W-1:0] modulus,
  input  logic [DEG_W-1:0] stall_count,
  input  logic [RAT_W-1:0] ratio,
  output logic [PER_W-1:0] period,
  output logic [TB_W-1:0]  interval,
  output logic [DEG_W-1:0] degree_count,
  output logic             angle_inc,
  output logic             stall_irq,
  output logic             edge_seen
);

  localparam int SCL_W = TB_W + RAT_W;
  localparam logic [TB_W-1:0] DEF_INT = {1'b1, {(TB_W-1){1'b0}}};

  logic            pin_q;
  logic            first_seen;
  logic            cmp_en;
  logic [TB_W-1:0] cmp_time;
  logic [TB_W-1:0] ref_time;

  wire tooth   = edge_rising ? (sensor_pin & ~pin_q) : (~sensor_pin & pin_q);
  wire cmp_hit = cmp_en & (timebase == cmp_time);
  wire seed_ok = (interval_seed != '0) & ~interval_seed[TB_W-1];

  wire [DEG_W-1:0] deg_next = (&degree_count) ? degree_count : degree_count + 1'b1;

  wire [TB_W-1:0]  elapsed    = timebase - ref_time;
  wire [PER_W-1:0] ticks_time = {{TB_W{1'b0}}, degree_count} * {{DEG_W{1'b0}}, interval};
  wire [PER_W-1:0] period_new = ticks_time + {{DEG_W{1'b0}}, elapsed};

  wire             quarter_big = |period_new[PER_W-1:TB_W+2];
  wire [TB_W-1:0]  quarter     = quarter_big ? {TB_W{1'b1}} : period_new[TB_W+1:2];
  wire [SCL_W-1:0] scaled      = {{RAT_W{1'b0}}, quarter} * {{TB_W{1'b0}}, ratio};
  wire [TB_W-1:0]  intv_new    = scaled[SCL_W-1:RAT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q        <= 1'b0;
      first_seen   <= 1'b0;
      cmp_en       <= 1'b0;
      cmp_time     <= '0;
      ref_time     <= '0;
      period       <= '0;
      interval     <= DEF_INT;
      degree_count <= '0;
      angle_inc    <= 1'b0;
      stall_irq    <= 1'b0;
      edge_seen    <= 1'b0;
    end else begin
      pin_q     <= sensor_pin;
      angle_inc <= 1'b0;
      stall_irq <= 1'b0;
      edge_seen <= 1'b0;
      if (init) begin
        interval     <= seed_ok ? interval_seed : DEF_INT;
        degree_count <= '0;
        first_seen   <= 1'b0;
        cmp_en       <= 1'b0;
      end else if (tooth) begin
        ref_time <= timebase;
        cmp_en   <= 1'b1;
        if (!first_seen) begin
          first_seen <= 1'b1;
          cmp_time   <= timebase + interval;
        end else begin
          period       <= period_new;
          interval     <= intv_new;
          degree_count <= '0;
          cmp_time     <= timebase + intv_new;
          edge_seen    <= 1'b1;
        end
      end else if (cmp_hit) begin
        ref_time     <= cmp_time;
        cmp_time     <= cmp_time + interval;
        degree_count <= deg_next;
        if (deg_next < modulus)
          angle_inc <= 1'b1;
        else if (deg_next >= stall_count)
          stall_irq <= 1'b1;
      end
    end
  end

endmodule

module deg_clk_interp_chk #(
  parameter int TB_W  = 16,
  parameter int DEG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic [DEG_W-1:0] modulus,
  input logic [DEG_W-1:0] stall_count,
  input logic [TB_W-1:0]  interval,
  input logic [DEG_W-1:0] degree_count,
  input logic             angle_inc,
  input logic             stall_irq,
  input logic             edge_seen
);

  p_init_interval_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> ((interval == {1'b1, {(TB_W-1){1'b0}}}) ||
              (interval != '0 && !interval[TB_W-1])) && degree_count == '0);

  p_tick_counts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    angle_inc |-> degree_count == DEG_W'($past(degree_count) + 1'b1));

  p_angle_below_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
    angle_inc |-> degree_count < modulus);

  p_stall_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stall_irq |-> (degree_count >= modulus && degree_count >= stall_count));

  p_pulse_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({angle_inc, stall_irq, edge_seen}) <= 1);

  p_edge_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |-> degree_count == '0);

endmodule

bind deg_clk_interp deg_clk_interp_chk #(.TB_W(TB_W), .DEG_W(DEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .modulus(modulus),
  .stall_count(stall_count), .interval(interval), .degree_count(degree_count),
  .angle_inc(angle_inc), .stall_irq(stall_irq), .edge_seen(edge_seen)
);

// File: tb/deg_clk_interp_bench.sv
module deg_clk_interp_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0;
  logic [15:0] interval_seed = '0;
  logic        sensor_pin = 1'b0;
  logic        edge_rising = 1'b1;
  logic [15:0] timebase;
  logic [7:0]  modulus = 8'd6;
  logic [7:0]  stall_count = 8'd200;
  logic [7:0]  ratio = 8'd255;
  logic [23:0] period;
  logic [15:0] interval;
  logic [7:0]  degree_count;
  logic        angle_inc, stall_irq, edge_seen;

  deg_clk_interp u_deg_clk_interp (
    .clk(clk), .rst_n(rst_n), .init(init), .interval_seed(interval_seed),
    .sensor_pin(sensor_pin), .edge_rising(edge_rising), .timebase(timebase),
    .modulus(modulus), .stall_count(stall_count), .ratio(ratio),
    .period(period), .interval(interval), .degree_count(degree_count),
    .angle_inc(angle_inc), .stall_irq(stall_irq), .edge_seen(edge_seen)
  );

  always #5 clk = ~clk;

  longint abs_t = 0;
  longint t_prev = 0;
  longint tb_step = 64'h800;
  assign timebase = abs_t[15:0];
  always @(posedge clk) begin
    t_prev <= abs_t;
    abs_t  <= abs_t + tb_step;
  end

  typedef struct {
    int     kind;
    longint t;
    int     deg;
    int     per;
    int     iv;
    string  ptag;
    string  itag;
  } item_t;

  item_t  expq[$];
  int     checks = 0;
  int     fails = 0;
  bit     done = 0;

  longint m_ref, m_cmp, m_per = 0;
  int     m_deg = 0, m_int = 16'h8000;
  bit     m_first = 0, m_en = 0, m_pin = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(int kind, longint t, int deg, int per, int iv, string pt, string it);
    item_t x;
    x.kind = kind; x.t = t; x.deg = deg; x.per = per; x.iv = iv; x.ptag = pt; x.itag = it;
    expq.push_back(x);
  endtask

  task automatic advance_to(longint x);
    while (m_en && m_cmp < x) begin
      if (m_cmp % tb_step != 0) begin
        m_en = 0;
        break;
      end
      m_deg = (m_deg == 255) ? 255 : m_deg + 1;
      if (m_deg < int'(modulus)) push(0, m_cmp, m_deg, 0, 0, "R4", "R4");
      else if (m_deg >= int'(stall_count)) push(1, m_cmp, m_deg, 0, 0, "R5", "R5");
      m_ref = m_cmp;
      m_cmp = m_cmp + ((m_int == 0) ? 65536 : m_int);
    end
    while (abs_t != x) @(negedge clk);
  endtask

  task automatic toggle(longint x);
    bit qual, hit;
    longint el, per, q4;
    hit = m_en && (m_cmp == x);
    advance_to(x);
    m_pin = !m_pin;
    sensor_pin = m_pin;
    qual = edge_rising ? m_pin : !m_pin;
    if (!qual) return;
    if (!m_first) begin
      m_first = 1;
      m_ref = x;
      m_cmp = x + ((m_int == 0) ? 65536 : m_int);
      m_en = 1;
      @(negedge clk);
      chk(edge_seen == 1'b0, "R2", "edge_seen on first edge", edge_seen, 0);
      chk(period == m_per[23:0], "R2", "period after first edge", period, m_per);
    end else begin
      el  = (x - m_ref) & 64'hFFFF;
      per = (longint'(m_deg) * m_int + el) & 64'hFFFFFF;
      q4  = per >> 2;
      if (q4 > 65535) q4 = 65535;
      m_int = int'((q4 * ratio) >> 8);
      push(2, x, 0, int'(per), m_int,
           hit ? "R11" : (edge_rising ? "R6" : "R10"),
           ((per >> 2) > 65535) ? "R8" : "R7");
      m_per = per;
      m_deg = 0;
      m_ref = x;
      m_cmp = x + ((m_int == 0) ? 65536 : m_int);
      m_en = 1;
    end
  endtask

  task automatic do_init(longint x, logic [15:0] seed);
    advance_to(x);
    init = 1'b1;
    interval_seed = seed;
    @(negedge clk);
    init = 1'b0;
    m_int = (seed == 0 || seed[15]) ? 16'h8000 : int'(seed);
    m_deg = 0; m_first = 0; m_en = 0;
    chk(interval == m_int[15:0], "R1", "interval after init", interval, m_int);
    chk(degree_count == 8'd0, "R1", "degree after init", degree_count, 0);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && (angle_inc || stall_irq || edge_seen)) begin
      if (expq.size() == 0) begin
        chk(0, "R3", "unexpected pulse at time", t_prev, -1);
      end else begin
        item_t e;
        int kind;
        e = expq.pop_front();
        kind = angle_inc ? 0 : (stall_irq ? 1 : 2);
        chk(kind == e.kind, (e.kind == 2) ? "R9" : e.ptag, "pulse kind", kind, e.kind);
        chk(t_prev == e.t, "R3", "event time", t_prev, e.t);
        if (e.kind == 2) begin
          chk(period == e.per[23:0], e.ptag, "period", period, e.per);
          chk(interval == e.iv[15:0], e.itag, "interval", interval, e.iv);
          chk(degree_count == 8'd0, "R9", "degree after edge", degree_count, 0);
        end else begin
          chk(degree_count == e.deg[7:0], "R3", "degree count", degree_count, e.deg);
        end
      end
    end
  end

  initial begin
    longint t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(interval == 16'h8000, "R12", "reset interval", interval, 16'h8000);
    chk(period == 24'd0, "R12", "reset period", period, 0);
    chk(degree_count == 8'd0, "R12", "reset degree", degree_count, 0);
    chk({angle_inc, stall_irq, edge_seen} == 3'b000, "R12", "reset pulses",
        {angle_inc, stall_irq, edge_seen}, 0);

    // Coarse timebase: long gaps at 0x8000 interval drive the R8 saturation
    do_init(abs_t + 2 * 64'h800, 16'h0000);
    t = abs_t + 4 * 64'h800;
    toggle(t);
    toggle(t + 64'h1000);
    toggle(t + 9 * 64'h8000 + 64'h800);
    toggle(abs_t + 2 * 64'h800);
    do_init(abs_t + 2 * 64'h800, 16'h9000);
    do_init(abs_t + 2 * 64'h800, 16'd100);
    chk(interval == 16'd100, "R1", "positive seed kept", interval, 100);

    // Fine timebase
    @(negedge clk);
    tb_step = 1;
    modulus = 8'd6; stall_count = 8'd8; ratio = 8'd64;
    @(negedge clk);
    t = abs_t + 10;
    toggle(t);        toggle(t + 100);
    toggle(t + 450);  toggle(t + 550);
    toggle(t + 900);  toggle(t + 1000);
    toggle(t + 1200); toggle(t + 1250);
    toggle(t + 1800); toggle(t + 1801);
    // R11: next tooth lands exactly on the third scheduled tick
    t = m_ref + 3 * m_int;
    toggle(t);
    toggle(t + 1);
    ratio = 8'd200; modulus = 8'd20; stall_count = 8'd30;
    toggle(t + 700);  toggle(t + 760);
    toggle(t + 1300); toggle(t + 1400);

    // R10: falling edges only; rising transitions must leave no trace
    do_init(abs_t + 5, 16'd50);
    edge_rising = 1'b0;
    modulus = 8'd10; stall_count = 8'd12; ratio = 8'd128;
    t = abs_t + 10;
    for (int k = 1; k <= 8; k++) toggle(t + k * 300);

    advance_to(abs_t + 2000);
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R3", "missing expected pulses", expq.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule